// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Latch Register

This block turns a serial bit stream into a parallel word in two stages. A shift chain takes one bit per rising edge of its shift clock. A holding register copies the whole chain on a rising edge of a separate storage clock, and only the holding register drives the parallel outputs. A consumer therefore sees a word change all at once and never sees bits rippling in during a shift.

Each stage has its own clock and its own asynchronous, active-low clear. The last bit of the shift chain also leaves the block as a cascade output. Feeding that output into the serial input of a second instance gives a wider converter. The two clocks can be driven separately. They can also be tied to one net, and then the holding register always shows the chain as it stood one pulse earlier.

Top module: `serial_latch_reg`

## Requirements
- R1: On each rising edge of `shift_clk` with `shift_clr_n` high, `ser_in` enters stage 0 and stage i takes the old value of stage i-1, for i from 1 to W-1.
- R2: On each rising edge of `store_clk` with `store_clr_n` high, `par_out[i]` takes shift stage i for every i. Bit 0 of `par_out` is the newest serial bit.
- R3: `par_out` does not change on shift clock edges. Only a storage clock edge or the storage clear changes it.
- R4: Driving `shift_clr_n` low zeroes the shift chain at once, with no clock edge, and leaves `par_out` unchanged.
- R5: Driving `store_clr_n` low zeroes `par_out` at once, with no clock edge, and leaves the shift chain (and so `cascade_out`) unchanged.
- R6: `cascade_out` always equals the last shift stage (W-1), so it updates on shift clock edges.
- R7: While `shift_clr_n` is low, rising edges of `shift_clk` leave the chain at zero.
- R8: While `store_clr_n` is low, rising edges of `store_clk` leave `par_out` at zero.
- R9: When both clocks rise on the same edge, `par_out` takes the chain contents from before that edge's shift.
- R10: When the `cascade_out` of one instance drives the `ser_in` of a second instance on shared clocks, 2W shift pulses and one storage pulse leave the first 2W serial bits split across the two instances. The oldest W bits are in the second instance, with the oldest bit at index W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift chain clock, rising edge |
| shift_clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| store_clk | input | 1 | Holding register clock, rising edge |
| store_clr_n | input | 1 | Asynchronous clear of the holding register, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_out | output | W | Holding register contents |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
A shift and a capture can fall on the same edge. This is provoked by raising both clocks in the same time step, and again for a whole tied byte. The bench judges it against the chain contents its model held before that shift. If the capture instead saw the post-shift value, the result would be off by one stage. A clear can also meet the other stage's clock. The bench holds each clear low across edges of its own clock and checks that the other stage's state is untouched.

// File: rtl/serial_latch_pkg.sv
package serial_latch_pkg;

    localparam int DEF_WIDTH = 8;

    typedef enum logic {
        STAGE_CLEARED = 1'b0,
        STAGE_ACTIVE  = 1'b1
    } stage_state_e;

    function automatic stage_state_e clr_state(input logic clr_n);
        return clr_n ? STAGE_ACTIVE : STAGE_CLEARED;
    endfunction

endpackage

// File: rtl/sl_shift_stage.sv
module sl_shift_stage
    import serial_latch_pkg::*;
#(
    parameter int W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         tail
);

    logic [W-1:0] feed;

    assign feed = {q[W-2:0], din};

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge clr_n) begin
            if (clr_state(clr_n) == STAGE_CLEARED) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= feed[i];
            end
        end
    end

    assign tail = q[W-1];

endmodule

// File: rtl/sl_hold_stage.sv
module sl_hold_stage
    import serial_latch_pkg::*;
#(
    parameter int W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (clr_state(clr_n) == STAGE_CLEARED) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg
    import serial_latch_pkg::*;
#(
    parameter int W = DEF_WIDTH
) (
    input  logic         shift_clk,
    input  logic         shift_clr_n,
    input  logic         store_clk,
    input  logic         store_clr_n,
    input  logic         ser_in,
    output logic [W-1:0] par_out,
    output logic         cascade_out
);

    logic [W-1:0] shift_q;

    sl_shift_stage #(.W(W)) u_shift (
        .clk   (shift_clk),
        .clr_n (shift_clr_n),
        .din   (ser_in),
        .q     (shift_q),
        .tail  (cascade_out)
    );

    sl_hold_stage #(.W(W)) u_hold (
        .clk   (store_clk),
        .clr_n (store_clr_n),
        .d     (shift_q),
        .q     (par_out)
    );

endmodule

// File: rtl/serial_latch_reg_chk.sv
module serial_latch_reg_chk #(
    parameter int W = 8
) (
    input logic         shift_clk,
    input logic         shift_clr_n,
    input logic         store_clk,
    input logic         store_clr_n,
    input logic [W-1:0] sr_q,
    input logic [W-1:0] par_out
);

    // R1: each stage takes its lower neighbour's previous value
    p_shift_adv_r1: assert property (
        @(posedge shift_clk) disable iff (!shift_clr_n)
        1'b1 |=> (sr_q[W-1:1] == $past(sr_q[W-2:0]))
    );

    // R2: holding register shows the chain sampled at the previous capture edge
    p_store_copy_r2: assert property (
        @(posedge store_clk) disable iff (!store_clr_n)
        1'b1 |=> (par_out == $past(sr_q))
    );

    // R4 / R7: chain is empty whenever its clear is seen low at a shift edge
    p_shift_clr_r4: assert property (
        @(posedge shift_clk) !shift_clr_n |-> (sr_q == '0)
    );

    // R5 / R8: outputs are empty whenever the storage clear is seen low
    p_hold_clr_r5: assert property (
        @(posedge store_clk) !store_clr_n |-> (par_out == '0)
    );

endmodule

bind serial_latch_reg serial_latch_reg_chk #(.W(W)) u_chk (
    .shift_clk   (shift_clk),
    .shift_clr_n (shift_clr_n),
    .store_clk   (store_clk),
    .store_clr_n (store_clr_n),
    .sr_q        (shift_q),
    .par_out     (par_out)
);

// File: tb/serial_latch_reg_test.sv
module serial_latch_reg_test;

    localparam int W = 8;

    typedef struct {
        logic [2*W-1:0] exp;
        string          tag;
    } sb_item_t;

    logic         sclk  = 1'b0;
    logic         rclk  = 1'b0;
    logic         sclr  = 1'b1;
    logic         rclr  = 1'b1;
    logic         ser   = 1'b0;
    logic [W-1:0] par_a;
    logic [W-1:0] par_b;
    logic         casc_a;
    logic         casc_b;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [W-1:0] ma = '0, mb = '0, ha = '0, hb = '0;
    sb_item_t sbq[$];
    event store_done;

    serial_latch_reg #(.W(W)) uut (
        .shift_clk(sclk), .shift_clr_n(sclr), .store_clk(rclk), .store_clr_n(rclr),
        .ser_in(ser), .par_out(par_a), .cascade_out(casc_a)
    );

    serial_latch_reg #(.W(W)) uut_b (
        .shift_clk(sclk), .shift_clr_n(sclr), .store_clk(rclk), .store_clr_n(rclr),
        .ser_in(casc_a), .par_out(par_b), .cascade_out(casc_b)
    );

    task automatic chk(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_shift(input logic b);
        if (sclr) begin
            mb = {mb[W-2:0], ma[W-1]};
            ma = {ma[W-2:0], b};
        end
    endtask

    task automatic shift_bit(input logic b);
        ser = b;
        #5 sclk = 1'b1;
        model_shift(b);
        #10 sclk = 1'b0;
        #5;
    endtask

    task automatic store_pulse(input string tag);
        sb_item_t it;
        if (rclr) begin
            ha = ma;
            hb = mb;
        end
        it.exp = {hb, ha};
        it.tag = tag;
        sbq.push_back(it);
        #5 rclk = 1'b1;
        #10 rclk = 1'b0;
        #5;
        -> store_done;
    endtask

    task automatic tied_pulse(input logic b, input string tag);
        sb_item_t it;
        if (rclr) begin
            ha = ma;
            hb = mb;
        end
        it.exp = {hb, ha};
        it.tag = tag;
        sbq.push_back(it);
        ser = b;
        #5 begin sclk = 1'b1; rclk = 1'b1; end
        model_shift(b);
        #10 begin sclk = 1'b0; rclk = 1'b0; end
        #5;
        -> store_done;
    endtask

    task automatic shift_byte(input logic [W-1:0] pat, input string tag);
        for (int i = W - 1; i >= 0; i--) begin
            shift_bit(pat[i]);
            chk({tag, " R6 cascade"}, {15'd0, casc_a}, {15'd0, ma[W-1]});
            chk({tag, " R3 outputs hold"}, {par_b, par_a}, {hb, ha});
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(store_done);
            #1;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: actual empty queue expected item");
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                chk(it.tag, {par_b, par_a}, it.exp);
            end
        end
    end

    // watchdog
    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #2 sclr = 1'b0; rclr = 1'b0;
        #10;
        chk("R4 R5 reset outputs", {par_b, par_a}, '0);
        chk("R4 reset cascade", {14'd0, casc_b, casc_a}, '0);
        sclr = 1'b1; rclr = 1'b1;
        #8;

        // R1 R2: several patterns through the chain
        shift_byte(8'hA5, "R1 A5");
        store_pulse("R2 store A5");
        shift_byte(8'h3C, "R1 3C");
        store_pulse("R2 store 3C");
        shift_byte(8'hFF, "R1 FF");
        shift_byte(8'h01, "R1 01");
        store_pulse("R2 store 01");

        // R4 R7: shift clear, outputs kept, edges ignored
        shift_byte(8'h96, "R1 96");
        store_pulse("R2 store 96");
        shift_bit(1'b1);
        sclr = 1'b0; ma = '0; mb = '0;
        #3;
        chk("R4 cascade cleared", {15'd0, casc_a}, '0);
        chk("R4 outputs untouched", {par_b, par_a}, {hb, ha});
        #2;
        shift_bit(1'b1);
        shift_bit(1'b1);
        chk("R7 cascade while cleared", {15'd0, casc_a}, '0);
        sclr = 1'b1;
        #5;
        store_pulse("R7 chain stayed empty");

        // R5 R8: storage clear
        shift_byte(8'h81, "R1 81");
        store_pulse("R2 store 81");
        shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0);
        rclr = 1'b0; ha = '0; hb = '0;
        #3;
        chk("R5 outputs cleared", {par_b, par_a}, '0);
        chk("R5 cascade untouched", {15'd0, casc_a}, {15'd0, ma[W-1]});
        #2;
        store_pulse("R8 store ignored");
        rclr = 1'b1;
        #5;
        store_pulse("R5 chain kept after clear");

        // R9: tied clocks, one pulse lag
        for (int i = W - 1; i >= 0; i--) begin
            tied_pulse(((8'h6B >> i) & 8'h01) != 0, "R9 tied lag");
        end
        tied_pulse(1'b0, "R9 tied lag final");

        // R10: two-instance chain, 16 bits then one capture
        begin
            logic [2*W-1:0] word = 16'hC3A9;
            for (int i = 2 * W - 1; i >= 0; i--) shift_bit(word[i]);
            store_pulse("R10 chain scoreboard");
            #2;
            chk("R10 first instance low half", {8'd0, par_a}, {8'd0, word[W-1:0]});
            chk("R10 second instance high half", {8'd0, par_b}, {8'd0, word[2*W-1:W]});
        end

        #20;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule